// File: doc/BRIEF.md
# Eight-bit Buffered-Compare Timer with Capture

This block is an 8-bit timer/counter attached to a byte-wide register port with two addresses: a control register and a data register. Its count enable comes from a free-running 10-bit prescaler, from the rising or falling edge of a synchronized external clock pin, or from nothing at all. In interval mode the counter runs from zero up to a compare value and then restarts, toggling the timer output and raising a match request each time. In capture mode the counter runs freely through 0xFF, raises an overflow request on each wrap, and copies its value into a capture register on each rising edge of the capture pin.

The compare value is not the data register. It is a hidden buffer that is loaded from the data register only when software sets the counter-clear bit. Software therefore writes the data register first and sets the clear bit afterwards. Each interrupt request flag has its own enable input and its own acknowledge input. Reads and writes are plain single-cycle register accesses with no back-pressure: a write takes effect at the clock edge where `reg_we` is high, and `reg_rdata` shows the addressed register combinationally.

Top module: `bct_timer`

## Requirements
- R1: After reset the control register reads 0x00, `tmr_out`, `irq_match` and `irq_ovf` are 0, and the counter and compare buffer hold 0.
- R2: Control register layout (address `reg_sel`=0): bit 5 is the mode (0 interval, 1 capture), bit 4 is counter-clear, and bits 3:0 are the clock select. Bits 7:6 always read 0. Bit 4 reads 1 for one cycle after it is written as 1 and then returns to 0 by itself.
- R3: Writing 1 to bit 4 of the control register sets the counter to 0 and copies the data register into the compare buffer. Writing the data register alone does not change the compare value that is in use.
- R4: In interval mode, a count tick at which the counter equals the buffer value B resets the counter to 0 and toggles `tmr_out`. The output therefore toggles once every B+1 ticks.
- R5: Clock select codes 0000, 0001, 0010, 0011, 0100 and 0111 produce no count ticks.
- R6: Clock select codes 1000 to 1111 tick once every 1, 2, 4, 8, 16, 64, 256 and 1024 system clocks, in that order.
- R7: Code 0101 ticks once for each rising edge of `ext_clk`. Code 0110 ticks once for each falling edge of `ext_clk`. The pin passes through a two-flop synchronizer first.
- R8: In capture mode the counter wraps from 0xFF to 0x00 and an overflow event occurs at the wrap. In interval mode no overflow event ever occurs.
- R9: In capture mode, a rising edge on `cap_pin` latches the current count into the capture register, and the data address (`reg_sel`=1) reads that register. In interval mode the data address reads back the data register.
- R10: A match or overflow event sets `irq_match` or `irq_ovf` only while `ie_match` or `ie_ovf` is 1. `ack_match` or `ack_ovf` clears the flag. If an event and an acknowledge occur in the same cycle, the event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register address: 0 control, 1 data |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| ie_match | input | 1 | Match request enable |
| ie_ovf | input | 1 | Overflow request enable |
| ack_match | input | 1 | Match request acknowledge |
| ack_ovf | input | 1 | Overflow request acknowledge |
| ext_clk | input | 1 | External count clock pin |
| cap_pin | input | 1 | Capture trigger pin |
| tmr_out | output | 1 | Interval-mode toggle output |
| irq_match | output | 1 | Match request flag |
| irq_ovf | output | 1 | Overflow request flag |

## Verification
The counter itself cannot be read at any port. Its rate is measured by taking two captures a known number of clocks apart and comparing the difference with the expected tick count. A fixed window also removes any dependence on the prescaler's free-running phase. The hidden buffer can be seen only through the toggle period of `tmr_out`. The bench rewrites the data register, shows that the period stays the same, and then performs a clear and shows that the period changes. Edge polarity on the external clock is separated by driving only one edge at a time and watching for a single toggle with a compare value of zero.

// File: rtl/bct_pkg.sv
package bct_pkg;

  // clock-select codes with behavioural meaning
  localparam logic [3:0] CS_EXT_RISE = 4'b0101;
  localparam logic [3:0] CS_EXT_FALL = 4'b0110;

  // number of prescaler bits that must be all ones for each internal tap
  function automatic int tap_shift(input int idx);
    case (idx)
      0: return 0;
      1: return 1;
      2: return 2;
      3: return 3;
      4: return 4;
      5: return 6;
      6: return 8;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/bct_prescaler.sv
module bct_prescaler #(
  parameter int PSC_W = 10,
  parameter int NTAPS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] csel,
  output logic       psc_tick
);
  localparam int SEL_W = $clog2(NTAPS);

  logic [PSC_W-1:0] div_q;
  logic [NTAPS-1:0] taps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + PSC_W'(1);
  end

  for (genvar g = 0; g < NTAPS; g++) begin : g_tap
    localparam int SH = bct_pkg::tap_shift(g);
    if (SH == 0) begin : g_full
      assign taps[g] = 1'b1;
    end else begin : g_div
      assign taps[g] = &div_q[SH-1:0];
    end
  end

  assign psc_tick = csel[3] & taps[csel[SEL_W-1:0]];

  // R6
  div2_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csel == 4'b1001 && $past(csel) == 4'b1001 && $past(psc_tick)) |-> !psc_tick);
  // R5
  no_int_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !csel[3] |-> !psc_tick);
endmodule

// File: rtl/bct_sync_edge.sv
module bct_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
  assign fall = ~sync_q[STAGES-1] & prev_q;

  // R7
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise, fall}));
  // R7
  no_back2back_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/bct_core.sv
module bct_core #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          mode_cap,
  input  logic          clr,
  input  logic [CW-1:0] load_val,
  input  logic          cap_evt,
  output logic          tgl_out,
  output logic          match_evt,
  output logic          ovf_evt,
  output logic [CW-1:0] cap_q
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cmp_q;
  logic          hit;

  assign hit       = (cnt_q == cmp_q);
  assign match_evt = tick & ~clr & ~mode_cap & hit;
  assign ovf_evt   = tick & ~clr & mode_cap & (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmp_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
      cmp_q <= load_val;
    end else if (tick) begin
      if (!mode_cap && hit) cnt_q <= '0;
      else                  cnt_q <= cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tgl_out <= 1'b0;
    else if (match_evt) tgl_out <= ~tgl_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cap_q <= '0;
    else if (cap_evt) cap_q <= cnt_q;
  end

  // R3
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
  // R4
  match_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> (cnt_q == '0) && (tgl_out != $past(tgl_out)));
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt_q) && $stable(cmp_q));
  // R8
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (cnt_q == '0));
  // R8
  no_ovf_interval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_cap |-> !ovf_evt);
endmodule

// File: rtl/bct_timer.sv
module bct_timer #(
  parameter int CW       = 8,
  parameter int PSC_W    = 10,
  parameter int SYNC_STG = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_sel,
  input  logic          reg_we,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          ie_match,
  input  logic          ie_ovf,
  input  logic          ack_match,
  input  logic          ack_ovf,
  input  logic          ext_clk,
  input  logic          cap_pin,
  output logic          tmr_out,
  output logic          irq_match,
  output logic          irq_ovf
);
  import bct_pkg::*;

  logic          mode_q, clr_q;
  logic [3:0]    cs_q;
  logic [CW-1:0] data_q;
  logic          wr_ctrl, wr_data;
  logic          psc_tick, ext_rise, ext_fall, cap_rise, cap_fall, tick;
  logic          match_evt, ovf_evt;
  logic [CW-1:0] cap_q;
  logic          wdata_unused;

  assign wr_ctrl      = reg_we & ~reg_sel;
  assign wr_data      = reg_we & reg_sel;
  assign wdata_unused = ^{reg_wdata[7:6], cap_fall};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      clr_q  <= 1'b0;
      cs_q   <= '0;
    end else if (wr_ctrl) begin
      mode_q <= reg_wdata[5];
      clr_q  <= reg_wdata[4];
      cs_q   <= reg_wdata[3:0];
    end else begin
      clr_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (wr_data) data_q <= reg_wdata[CW-1:0];
  end

  bct_prescaler #(.PSC_W(PSC_W), .NTAPS(8)) u_psc (
    .clk(clk), .rst_n(rst_n), .csel(cs_q), .psc_tick(psc_tick));

  bct_sync_edge #(.STAGES(SYNC_STG)) u_ext (
    .clk(clk), .rst_n(rst_n), .pin(ext_clk), .rise(ext_rise), .fall(ext_fall));

  bct_sync_edge #(.STAGES(SYNC_STG)) u_cap (
    .clk(clk), .rst_n(rst_n), .pin(cap_pin), .rise(cap_rise), .fall(cap_fall));

  always_comb begin
    case (cs_q)
      CS_EXT_RISE: tick = ext_rise;
      CS_EXT_FALL: tick = ext_fall;
      default:     tick = psc_tick;
    endcase
  end

  bct_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode_cap(mode_q), .clr(clr_q),
    .load_val(data_q), .cap_evt(cap_rise & mode_q), .tgl_out(tmr_out),
    .match_evt(match_evt), .ovf_evt(ovf_evt), .cap_q(cap_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_match <= 1'b0;
      irq_ovf   <= 1'b0;
    end else begin
      if (match_evt && ie_match) irq_match <= 1'b1;
      else if (ack_match)        irq_match <= 1'b0;
      if (ovf_evt && ie_ovf)     irq_ovf   <= 1'b1;
      else if (ack_ovf)          irq_ovf   <= 1'b0;
    end
  end

  always_comb begin
    if (!reg_sel) reg_rdata = {2'b00, mode_q, clr_q, cs_q};
    else          reg_rdata = 8'(mode_q ? cap_q : data_q);
  end

  // R2
  clr_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_q && !wr_ctrl) |=> !clr_q);
  // R10
  ack_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_match && !(match_evt && ie_match)) |=> !irq_match);
  // R10
  ack_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ovf && !(ovf_evt && ie_ovf)) |=> !irq_ovf);
  // R10
  match_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_match) |-> $past(ie_match));
endmodule

// File: tb/sim_bct_timer.sv
module sim_bct_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_sel = 1'b0, reg_we = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic ie_match = 1'b0, ie_ovf = 1'b0, ack_match = 1'b0, ack_ovf = 1'b0;
  logic ext_clk = 1'b0, cap_pin = 1'b0;
  logic tmr_out, irq_match, irq_ovf;
  int checks = 0, errors = 0, cycles = 0;

  always #5 clk = ~clk;

  bct_timer u0 (.*);

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] v);
    reg_sel = sel; reg_wdata = v; reg_we = 1'b1;
    cyc(1);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    reg_sel = sel; #1; v = reg_rdata;
  endtask

  task automatic toggles(input int n, output int t);
    logic last;
    t = 0; last = tmr_out;
    for (int i = 0; i < n; i++) begin
      cyc(1);
      if (tmr_out != last) t++;
      last = tmr_out;
    end
  endtask

  task automatic cap_pulse(output logic [7:0] v);
    cap_pin = 1'b1; cyc(3); cap_pin = 1'b0; cyc(5);
    rd(1'b1, v);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(1'b0, v);
    chk("R1 ctrl", v, 8'h00);
    chk("R1 outputs", {tmr_out, irq_match, irq_ovf}, 0);
  endtask

  task automatic t_ctrl();
    logic [7:0] v;
    wr(1'b0, 8'hFF);
    rd(1'b0, v);
    chk("R2 clear bit visible", v, 8'h3F);
    cyc(2);
    rd(1'b0, v);
    chk("R2 readback", v, 8'h2F);
    wr(1'b0, 8'h00);
  endtask

  task automatic t_interval();
    int t; logic [7:0] v;
    ie_match = 1'b1;
    wr(1'b1, 8'd3); wr(1'b0, 8'h18); cyc(10);
    toggles(40, t); chk("R4 period B=3", t, 10);
    chk("R10 match flag set", irq_match, 1);
    ie_match = 1'b0; ack_match = 1'b1; cyc(1); ack_match = 1'b0;
    chk("R10 ack clears", irq_match, 0);
    toggles(40, t); chk("R10 disabled stays clear", irq_match, 0);
    wr(1'b1, 8'd7);
    rd(1'b1, v); chk("R9 data readback interval", v, 8'd7);
    toggles(40, t); chk("R3 buffer not reloaded", t, 10);
    wr(1'b0, 8'h18); cyc(10);
    toggles(40, t); chk("R3 buffer reloaded on clear", t, 5);
  endtask

  task automatic t_stop();
    int t;
    wr(1'b0, 8'h00); cyc(2); toggles(40, t); chk("R5 code 0000", t, 0);
    wr(1'b0, 8'h03); cyc(2); toggles(40, t); chk("R5 code 0011", t, 0);
    wr(1'b0, 8'h07); cyc(2); toggles(40, t); chk("R5 code 0111", t, 0);
    wr(1'b0, 8'h01); cyc(2); toggles(40, t); chk("R5 code 0001", t, 0);
  endtask

  task automatic t_ext();
    logic o;
    ext_clk = 1'b0;
    wr(1'b1, 8'd0); wr(1'b0, 8'h15); cyc(6);
    o = tmr_out; ext_clk = 1'b1; cyc(6);
    chk("R7 rising edge counts", tmr_out, !o);
    o = tmr_out; ext_clk = 1'b0; cyc(6);
    chk("R7 falling ignored in 0101", tmr_out, o);
    wr(1'b0, 8'h16); cyc(6);
    o = tmr_out; ext_clk = 1'b1; cyc(6);
    chk("R7 rising ignored in 0110", tmr_out, o);
    ext_clk = 1'b0; cyc(6);
    chk("R7 falling edge counts", tmr_out, !o);
  endtask

  task automatic meas(input logic [3:0] cs, input int span, input int exp);
    logic [7:0] a, b;
    wr(1'b0, {4'h3, cs}); cyc(4);
    cap_pulse(a);
    cyc(span - 8);
    cap_pulse(b);
    chk($sformatf("R6 R9 rate code %b", cs), 8'(b - a), exp);
  endtask

  task automatic t_psc();
    meas(4'h8, 200, 200);
    meas(4'h9, 400, 200);
    meas(4'hA, 400, 100);
    meas(4'hB, 800, 100);
    meas(4'hC, 1600, 100);
    meas(4'hD, 6400, 100);
    meas(4'hE, 25600, 100);
    meas(4'hF, 25600, 25);
  endtask

  task automatic t_ovf();
    ie_ovf = 1'b1;
    wr(1'b0, 8'h38); cyc(300);
    chk("R8 overflow in capture", irq_ovf, 1);
    ie_ovf = 1'b0; ack_ovf = 1'b1; cyc(1); ack_ovf = 1'b0;
    chk("R10 ack clears overflow", irq_ovf, 0);
    ie_ovf = 1'b1;
    wr(1'b1, 8'hFF); wr(1'b0, 8'h18); cyc(700);
    chk("R8 no overflow in interval", irq_ovf, 0);
    ie_ovf = 1'b0;
  endtask

  initial begin
    cyc(3); rst_n = 1'b1; cyc(2);
    t_reset();
    t_ctrl();
    t_interval();
    t_stop();
    t_ext();
    t_psc();
    t_ovf();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule